// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a bank of independent 16-bit down counters sharing a small byte-wide host port. A host reaches each counter through its own data address and programs it through a single command address. A command picks the counter by a select field. It then either fixes that counter's byte access sequence, counting mode and number system, or takes a snapshot of the running count for a stable read. Each counter advances on its own count-enable strobe, and only while its level enable is high. It drives one output whose waveform depends on the mode.

Three behaviours are provided: an output that rises once the count runs out, a rate generator with a one-strobe low pulse per period, and a square wave. Counting runs in plain binary or in four-digit BCD. A reload value of zero stands for the largest count in either system. The bank size is a parameter, from one to three counters.

Top module: `ivt_timer`

## Requirements
- R1: Addresses 0, 1 and 2 reach the data registers of counters 0, 1 and 2, and address 3 is the command port. Command bits 7:6 pick the counter (00, 01, 10). The value 11 is ignored, and a data write to one counter leaves the others untouched.
- R2: With access code 01 (command bits 5:4), a data write sets the reload to {8'h00, byte}, and every read returns the low byte of the count.
- R3: With access code 10, a data write sets the reload to {byte, 8'h00}, and every read returns the high byte of the count.
- R4: With access code 11, writes and reads each step through low byte then high byte, with separate pointers. The reload takes effect once the high byte is written, and any command to that counter sets both pointers back to low.
- R5: Access code 00 is a latch command. It copies the running count into a snapshot that later reads return, while counting goes on undisturbed.
- R6: A snapshot is held until every byte its access code allows has been read. Latch commands that arrive before then are ignored.
- R7: Mode 0 (command bits 3:1 = 0) drives the output low when a command or a complete count is written. The count loads on the next enabled strobe, and the output rises on the enabled strobe that takes the count to zero. It then stays high, while the count keeps wrapping, until a new count is written. Every output is low after reset.
- R8: Mode 2 (codes 2 or 6) reloads automatically, giving a period of N strobes. The output is low exactly while the count equals 1 and high otherwise, and high after the command and after the load.
- R9: Mode 3 (codes 3 or 7) gives a square wave with a period of N strobes. The output is high for (N+1)/2 strobes and low for N/2, starting high at the load.
- R10: When command bit 0 is set, the count steps down in four-digit BCD: 0x1000 goes to 0x0999, and 0x0000 goes to 0x9999.
- R11: A reload of zero counts as 65536 strobes in binary and 10000 in BCD.
- R12: A counter moves only on strobes of its own count enable that arrive while its level enable is high. Strobes that arrive while the enable is low, including the loading strobe, are lost.
- R13: Mode codes 1, 4 and 5 behave as mode 0.
- R14: Read data appears on rdata one cycle after a read strobe and holds until the next read strobe. A read of address 3 returns 0, and rdata is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Host address: counter data 0..2, command 3 |
| wdata | input | 8 | Host write data |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| rdata | output | 8 | Registered host read data |
| cnt_en | input | NUM_CH | Per-counter count-enable strobe |
| gate | input | NUM_CH | Per-counter level enable |
| tmr_out | output | NUM_CH | Per-counter output |

## Verification
The bench builds the block with its defaults: three counters of 16 bits each. In that configuration, it can sweep every reload from 2 to 9 over two full periods in both the rate and square-wave modes, and check the output on every strobe. A 16-bit counter also puts the zero-reload terminal count within reach, 65536 strobes in binary and 10000 in BCD, so the maximum-count rule is checked at its true limit and not at a scaled-down width. BCD borrow across all four digits and the wrap from 0000 to 9999 are checked by reading the live count back through the host port.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NDIG   = CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    MD_TERM = 2'd0,
    MD_RATE = 2'd1,
    MD_SQW  = 2'd2
  } mode_e;

  function automatic mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd2, 3'd6: decode_mode = MD_RATE;
      3'd3, 3'd7: decode_mode = MD_SQW;
      default:    decode_mode = MD_TERM;
    endcase
  endfunction

  function automatic logic bcd_ok(input logic [CNT_W-1:0] v);
    bcd_ok = 1'b1;
    for (int d = 0; d < NDIG; d++)
      if (v[4*d +: 4] > 4'd9) bcd_ok = 1'b0;
  endfunction
endpackage

// File: rtl/ivt_decr.sv
module ivt_decr #(
  parameter int W    = 16,
  parameter int STEP = 1
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] dec
);
  localparam int NDIG = W / 4;

  logic [W-1:0]    bin_dec;
  logic [W-1:0]    bcd_dec;
  logic [NDIG-1:0] brw;

  assign bin_dec = val - W'(STEP);
  assign brw[0]  = 1'b0;

  generate
    for (genvar d = 0; d < NDIG; d++) begin : g_dig
      logic [4:0] sub;
      logic [4:0] raw;
      assign sub = (d == 0) ? 5'(STEP) : 5'd0;
      assign raw = {1'b0, val[4*d +: 4]} - sub - {4'd0, brw[d]};
      assign bcd_dec[4*d +: 4] = raw[4] ? 4'(raw + 5'd10) : raw[3:0];
      if (d < NDIG - 1) begin : g_brw
        assign brw[d+1] = raw[4];
      end
    end
  endgenerate

  assign dec = bcd ? bcd_dec : bin_dec;
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              latch_cmd,
  input  logic [5:0]        ctrl_data,
  input  logic              wr_we,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_re,
  input  logic              cnt_en,
  input  logic              gate,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              tmr_out
);
  acc_e              acc_q, acc_d;
  mode_e             mode_q, mode_d;
  logic              bcd_q, bcd_d;
  logic [CNT_W-1:0]  reload_q, reload_d, count_q, count_d, snap_q, snap_d;
  logic [BYTE_W-1:0] lo_hold_q, lo_hold_d;
  logic              wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic              latched_q, latched_d, running_q, running_d;
  logic              pend_q, pend_d, out_q, out_d;
  logic              tick, wr_done;
  logic [CNT_W-1:0]  dec1, dec2, rd_src;

  ivt_decr #(.W(CNT_W), .STEP(1)) u_dec1 (.val(count_q), .bcd(bcd_q), .dec(dec1));
  ivt_decr #(.W(CNT_W), .STEP(2)) u_dec2 (.val(count_q), .bcd(bcd_q), .dec(dec2));

  assign tick = cnt_en & gate;

  always_comb begin
    acc_d = acc_q;  mode_d = mode_q;  bcd_d = bcd_q;
    reload_d = reload_q;  count_d = count_q;  snap_d = snap_q;
    lo_hold_d = lo_hold_q;  wr_ptr_d = wr_ptr_q;  rd_ptr_d = rd_ptr_q;
    latched_d = latched_q;  running_d = running_q;
    pend_d = pend_q;  out_d = out_q;  wr_done = 1'b0;
    if (ctrl_we) begin
      acc_d     = acc_e'(ctrl_data[5:4]);
      mode_d    = decode_mode(ctrl_data[3:1]);
      bcd_d     = ctrl_data[0];
      wr_ptr_d  = 1'b0;
      rd_ptr_d  = 1'b0;
      latched_d = 1'b0;
      running_d = 1'b0;
      pend_d    = 1'b0;
      out_d     = (decode_mode(ctrl_data[3:1]) != MD_TERM);
    end else begin
      if (latch_cmd && !latched_q) begin
        latched_d = 1'b1;
        snap_d    = count_q;
      end
      if (wr_we) begin
        case (acc_q)
          ACC_LO: begin reload_d = {{BYTE_W{1'b0}}, wr_data}; wr_done = 1'b1; end
          ACC_HI: begin reload_d = {wr_data, {BYTE_W{1'b0}}}; wr_done = 1'b1; end
          ACC_LOHI: begin
            if (!wr_ptr_q) begin
              lo_hold_d = wr_data;
              wr_ptr_d  = 1'b1;
            end else begin
              reload_d = {wr_data, lo_hold_q};
              wr_ptr_d = 1'b0;
              wr_done  = 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (rd_re) begin
        if (acc_q == ACC_LOHI) rd_ptr_d = ~rd_ptr_q;
        if (latched_q && (acc_q != ACC_LOHI || rd_ptr_q)) latched_d = 1'b0;
      end
      if (tick) begin
        if (pend_q) begin
          count_d   = reload_q;
          running_d = 1'b1;
          pend_d    = 1'b0;
          out_d     = (mode_q != MD_TERM);
        end else if (running_q) begin
          case (mode_q)
            MD_RATE: begin
              if (count_q == CNT_W'(1)) begin
                count_d = reload_q;
                out_d   = 1'b1;
              end else begin
                count_d = dec1;
                out_d   = (dec1 != CNT_W'(1));
              end
            end
            MD_SQW: begin
              if (count_q == CNT_W'(1) || count_q == CNT_W'(2)) begin
                out_d   = ~out_q;
                count_d = out_q ? {reload_q[CNT_W-1:1], 1'b0} : reload_q;
              end else begin
                count_d = dec2;
              end
            end
            default: begin
              count_d = dec1;
              if (dec1 == '0) out_d = 1'b1;
            end
          endcase
        end
      end
      if (wr_done && (mode_q == MD_TERM || !running_q)) begin
        pend_d = 1'b1;
        if (mode_q == MD_TERM) out_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= ACC_LO;  mode_q <= MD_TERM;  bcd_q <= 1'b0;
      reload_q <= '0;  count_q <= '0;  snap_q <= '0;  lo_hold_q <= '0;
      wr_ptr_q <= 1'b0;  rd_ptr_q <= 1'b0;  latched_q <= 1'b0;
      running_q <= 1'b0;  pend_q <= 1'b0;  out_q <= 1'b0;
    end else begin
      acc_q <= acc_d;  mode_q <= mode_d;  bcd_q <= bcd_d;
      reload_q <= reload_d;  count_q <= count_d;  snap_q <= snap_d;  lo_hold_q <= lo_hold_d;
      wr_ptr_q <= wr_ptr_d;  rd_ptr_q <= rd_ptr_d;  latched_q <= latched_d;
      running_q <= running_d;  pend_q <= pend_d;  out_q <= out_d;
    end
  end

  assign rd_src  = latched_q ? snap_q : count_q;
  assign rd_byte = (acc_q == ACC_HI || (acc_q == ACC_LOHI && rd_ptr_q))
                   ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
  assign tmr_out = out_q;

  assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latched_q && $past(latched_q) |-> $stable(snap_q));

  assert_term_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MD_TERM && $rose(out_q) |-> count_q == '0);

  assert_rate_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MD_RATE && running_q && !pend_q && !out_q && reload_q != CNT_W'(1)
    |-> count_q == CNT_W'(1));

  assert_bcd_digits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ctrl_we && running_q && bcd_q && bcd_ok(count_q) && bcd_ok(reload_q)
    |=> bcd_ok(count_q));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rdata,
  input  logic [NUM_CH-1:0] cnt_en,
  input  logic [NUM_CH-1:0] gate,
  output logic [NUM_CH-1:0] tmr_out
);
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              cmd_wr;
  logic [BYTE_W-1:0] ch_byte [NUM_CH];
  logic [BYTE_W-1:0] rd_sel;
  logic [BYTE_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cmd_wr = wr_en && (addr == CMD_ADDR);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_hit;
      assign sel_hit = cmd_wr && (wdata[7:6] == 2'(i));
      ivt_channel u_ch (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .ctrl_we   (sel_hit && (wdata[5:4] != ACC_LATCH)),
        .latch_cmd (sel_hit && (wdata[5:4] == ACC_LATCH)),
        .ctrl_data (wdata[5:0]),
        .wr_we     (wr_en && (addr == 2'(i))),
        .wr_data   (wdata),
        .rd_re     (rd_en && (addr == 2'(i))),
        .cnt_en    (cnt_en[i]),
        .gate      (gate[i]),
        .rd_byte   (ch_byte[i]),
        .tmr_out   (tmr_out[i])
      );
    end
  endgenerate

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == 2'(i)) rd_sel = ch_byte[i];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_sel;
  end
  assign rdata = rdata_q;

  assert_rdata_hold_R14: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(rd_en) |-> $stable(rdata_q));
endmodule

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;
  localparam int NCH = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     addr;
  logic [7:0]     wdata, rdata;
  logic           wr_en, rd_en;
  logic [NCH-1:0] cnt_en, gate, tmr_out;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ivt_timer #(.NUM_CH(NCH)) u_ivt_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .cnt_en(cnt_en), .gate(gate), .tmr_out(tmr_out));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi); v = {hi, lo};
  endtask

  task automatic run(input int ch, input int n);
    @(negedge clk); cnt_en[ch] = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en[ch] = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b, v;
    logic [15:0] w;
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    cnt_en = '0; gate = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 reset outputs", tmr_out, 0);
    chk("R14 reset rdata", rdata, 0);

    // R7: terminal count sweep
    for (int n = 1; n <= 6; n++) begin
      wr(3, 8'h30); wr(0, 8'(n)); wr(0, 8'h00);
      chk("R7 low after write", tmr_out[0], 0);
      run(0, n);
      chk("R7 low before zero", tmr_out[0], 0);
      run(0, 1);
      chk("R7 high at zero", tmr_out[0], 1);
    end
    rd16(0, w); chk("R7 count at zero", w, 0);
    run(0, 3);
    chk("R7 stays high while wrapping", tmr_out[0], 1);
    wr(0, 8'h05); wr(0, 8'h00);
    chk("R7 low on new count", tmr_out[0], 0);

    // R11: zero reload is the maximum count
    wr(3, 8'h30); wr(0, 8'h00); wr(0, 8'h00);
    run(0, 65536); chk("R11 binary zero not yet", tmr_out[0], 0);
    run(0, 1);     chk("R11 binary zero expiry", tmr_out[0], 1);
    wr(3, 8'h31); wr(0, 8'h00); wr(0, 8'h00);
    run(0, 10000); chk("R11 bcd zero not yet", tmr_out[0], 0);
    run(0, 1);     chk("R11 bcd zero expiry", tmr_out[0], 1);

    // R10: BCD borrow and wrap
    wr(3, 8'h31); wr(0, 8'h00); wr(0, 8'h10);
    run(0, 2); rd16(0, w); chk("R10 bcd 1000-1", w, 16'h0999);
    run(0, 1000); rd16(0, w); chk("R10 bcd wrap", w, 16'h9999);

    // R8: rate generator sweep
    for (int n = 2; n <= 9; n++) begin
      wr(3, 8'h74); wr(1, 8'(n)); wr(1, 8'h00);
      chk("R8 high after command", tmr_out[1], 1);
      run(1, 1);
      chk("R8 high at load", tmr_out[1], 1);
      for (int k = 1; k <= 2 * n; k++) begin
        run(1, 1);
        chk("R8 rate pattern", tmr_out[1], ((k % n) != n - 1) ? 1 : 0);
      end
    end
    wr(3, 8'h75); wr(1, 8'h12); wr(1, 8'h00);
    run(1, 1);
    for (int k = 1; k <= 24; k++) begin
      run(1, 1);
      chk("R10 bcd rate pattern", tmr_out[1], ((k % 12) != 11) ? 1 : 0);
    end

    // R9: square wave sweep
    for (int n = 2; n <= 9; n++) begin
      wr(3, 8'hB6); wr(2, 8'(n)); wr(2, 8'h00);
      run(2, 1);
      chk("R9 high at load", tmr_out[2], 1);
      for (int k = 1; k <= 2 * n; k++) begin
        run(2, 1);
        chk("R9 square pattern", tmr_out[2], ((k % n) < (n + 1) / 2) ? 1 : 0);
      end
    end
    wr(3, 8'hB7); wr(2, 8'h00); wr(2, 8'h00);
    run(2, 1);
    run(2, 4999); chk("R11 bcd square high end", tmr_out[2], 1);
    run(2, 1);    chk("R11 bcd square low start", tmr_out[2], 0);
    run(2, 4999); chk("R11 bcd square low end", tmr_out[2], 0);
    run(2, 1);    chk("R11 bcd square period", tmr_out[2], 1);

    // R2 / R3: single-byte access
    wr(3, 8'h10); wr(0, 8'h47); run(0, 1);
    rd(0, b); chk("R2 low byte", b, 8'h47);
    rd(0, b); chk("R2 low byte again", b, 8'h47);
    run(0, 1); rd(0, b); chk("R2 low byte counting", b, 8'h46);
    wr(3, 8'h20); wr(0, 8'h02); run(0, 2);
    rd(0, b); chk("R3 high byte", b, 8'h01);
    rd(0, b); chk("R3 high byte again", b, 8'h01);

    // R5 / R6: latch
    wr(3, 8'h34); wr(0, 8'hE8); wr(0, 8'h03);
    run(0, 11);
    wr(3, 8'h00); run(0, 5); wr(3, 8'h00);
    rd(0, b); chk("R5 snapshot low", b, 8'hDE);
    run(0, 3);
    rd(0, b); chk("R6 snapshot high kept", b, 8'h03);
    rd16(0, w); chk("R5 count undisturbed", w, 16'd982);
    wr(3, 8'h14); wr(0, 8'h50); run(0, 1);
    wr(3, 8'h00); run(0, 5);
    rd(0, b); chk("R5 single byte snapshot", b, 8'h50);
    rd(0, b); chk("R6 released after one byte", b, 8'h4B);

    // R4: byte pointers
    wr(3, 8'h30); wr(0, 8'h34); wr(0, 8'h12); run(0, 1);
    rd(0, b); chk("R4 first read low", b, 8'h34);
    wr(3, 8'h30);
    rd(0, b); chk("R4 pointer reset low", b, 8'h34);
    rd(0, b); chk("R4 then high", b, 8'h12);
    wr(0, 8'h78); wr(3, 8'h30); wr(0, 8'h9A); wr(0, 8'hBC); run(0, 1);
    rd16(0, w); chk("R4 write pointer reset", w, 16'hBC9A);

    // R1: addressing and select
    wr(3, 8'h30);
    wr(3, 8'h70); wr(1, 8'h11); wr(1, 8'h22); run(1, 1);
    rd16(1, w); chk("R1 counter 1 data", w, 16'h2211);
    rd16(0, w); chk("R1 counter 0 untouched", w, 16'hBC9A);
    wr(3, 8'hF0);
    rd16(0, w); chk("R1 select 11 ignored", w, 16'hBC9A);
    rd(3, b); chk("R14 command port reads zero", b, 0);

    // R12: level enable
    wr(3, 8'h70); wr(1, 8'h20); wr(1, 8'h00);
    gate[1] = 1'b0; run(1, 5); gate[1] = 1'b1;
    run(1, 1); rd16(1, w); chk("R12 load waits for enable", w, 16'h0020);
    gate[1] = 1'b0; run(1, 5); gate[1] = 1'b1;
    run(0, 3);
    rd16(1, w); chk("R12 no count while disabled", w, 16'h0020);

    // R13: unsupported mode codes
    wr(3, 8'h32); wr(0, 8'h03); wr(0, 8'h00);
    chk("R13 code 1 low", tmr_out[0], 0);
    run(0, 3); chk("R13 code 1 before zero", tmr_out[0], 0);
    run(0, 1); chk("R13 code 1 at zero", tmr_out[0], 1);
    wr(3, 8'h3C); wr(0, 8'h03); wr(0, 8'h00);
    run(0, 2); chk("R8 code 6 high", tmr_out[0], 1);
    run(0, 1); chk("R8 code 6 pulse", tmr_out[0], 0);

    // R14: read data holds
    rd(0, v);
    run(0, 5);
    repeat (3) @(negedge clk);
    chk("R14 rdata holds", rdata, v);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule